// File: doc/BRIEF.md
# Delta-Panel Horizontal Timing Generator

This block produces the horizontal drive for an active-matrix LCD panel whose dots sit in a delta arrangement and whose column shift register is built into the glass. Each video line starts from a one-cycle `line_start` strobe. After that strobe the block sends a start pulse, then a two-phase complementary shift clock with a fixed number of periods, and three staggered sample-and-hold strobes that line up the red, green and blue video phases. It also drives a line-polarity flag, which the analog side uses to invert the video on every line, and a scan-direction level.

The block runs from a reference clock at four times the shift-clock rate, so one shift-clock period is four reference cycles. On every second line, the line whose polarity flag is high, the start pulse and the whole clock burst move later by one and a half shift periods (six reference cycles), which follows the horizontal dot offset between neighbouring rows. The aspect bit sets the burst length: 357 periods for a wide line and 269 for a narrow one. The aspect bit and the direction bit are captured only when a line starts.

Top module: `hdelta_htiming`

## Requirements
- R1: `hck2` is always the inverse of `hck1`. Outside the active burst `hck1` is low and `hck2` is high.
- R2: In the burst, `hck1` is high for two reference cycles and then low for two, so its period is four reference cycles.
- R3: Each line has exactly 357 rising edges of `hck1` when `wide_mode` was 1 at line start, and exactly 269 when it was 0.
- R4: Let E0 be the rising edge that samples `line_start` high, on a line with the polarity flag low. `hst` goes high after edge E0+LEAD+2 (LEAD defaults to 2) and stays high for four cycles. `hck1` first rises one cycle after `hst` rises, so `hst` is low-to-high while `hck1` is still low.
- R5: On a line whose polarity flag is high, `hst` and the whole `hck1`/strobe burst come six reference cycles later than in R4.
- R6: `line_pol` toggles at edge E0+1 of every line start. Its reset value is 0, so the first line has polarity 1.
- R7: `dir_out` takes the value of `dir_right` sampled for that line (1 = right scan, 0 = left scan). It changes at the same edge as `line_pol`.
- R8: Each `sh_strobe` bit is high for one reference cycle per shift period. Bit 0 is high one cycle after an `hck1` rise. In right scan, bit 1 is high two cycles after the rise and bit 2 three cycles after. In left scan, bits 1 and 2 swap those slots. Outside the burst all strobe bits are low.
- R9: Changes on `wide_mode` and `dir_right` when no line start is sampled have no effect on the line in progress or on the idle outputs.
- R10: A new `line_start` during a line abandons that line and begins a fresh one, timed as in R4/R5.
- R11: After reset, `hst`, `hck1` and `sh_strobe` are 0, `hck2` is 1, `line_pol` is 0 and `dir_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the shift-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe that begins a video line |
| wide_mode | input | 1 | Aspect select: 1 wide (357 periods), 0 narrow (269 periods) |
| dir_right | input | 1 | Horizontal scan direction: 1 right, 0 left |
| hst | output | 1 | Horizontal start pulse to the panel shift register |
| hck1 | output | 1 | Shift-clock phase one |
| hck2 | output | 1 | Shift-clock phase two, complement of `hck1` |
| dir_out | output | 1 | Scan-direction level latched per line |
| line_pol | output | 1 | Per-line video polarity flag |
| sh_strobe | output | 3 | Staggered RGB sample-and-hold strobes |

## Verification
The bench targets these corner cases:
- Lines of alternating polarity in both aspect modes. A design that applied the 1.5-period shift on the wrong lines, or used the wrong number of cycles, would put `hst` and every clock edge early or late.
- Full lines, with the `hck1` rising edges counted. An off-by-one at either end of the burst would show up as 356 or 358 edges, or as a stray edge in the idle tail.
- The aspect and direction inputs changed on every cycle of a line. This exposes a design that reads them live rather than from the line-start latch: the burst would be cut short or the strobe order would flip mid-line.
- Lines cut short by a new start at random points. A counter or flag that does not restart cleanly would be caught.

// File: rtl/hdelta_pkg.sv
package hdelta_pkg;

  // reference cycles per shift-clock period
  localparam int unsigned DIV = 4;
  // number of sample-and-hold channels
  localparam int unsigned NCH = 3;

  // tick index at which the start pulse begins
  function automatic int unsigned first_tick(input logic shift, input int unsigned lead,
                                             input int unsigned ofs);
    return lead + (shift ? ofs : 0);
  endfunction

  // reference cycles covered by the clock burst
  function automatic int unsigned span_ticks(input logic wide, input int unsigned n_wide,
                                             input int unsigned n_narrow);
    return DIV * (wide ? n_wide : n_narrow);
  endfunction

  // phase slot (0..3 after an hck1 rise) in which channel ch strobes
  function automatic logic [1:0] sh_slot(input int unsigned ch, input logic right);
    if (ch == 0) return 2'd1;
    if (right) return 2'(ch + 1);
    return (ch == 1) ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/hdelta_line_ctrl.sv
module hdelta_line_ctrl #(
  parameter int unsigned N_WIDE   = 357,
  parameter int unsigned N_NARROW = 269,
  parameter int unsigned LEAD     = 2,
  parameter int unsigned OFS      = 6,
  parameter int unsigned TW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          wide_mode,
  input  logic          dir_right,
  output logic          run,
  output logic [TW-1:0] tick,
  output logic          wide_l,
  output logic          right_l,
  output logic          shift_l,
  output logic          line_pol
);
  import hdelta_pkg::*;

  logic          ls_q;
  logic [TW-1:0] done_w;

  // tick at which the line is over
  assign done_w = TW'(first_tick(shift_l, LEAD, OFS) + 1 + span_ticks(wide_l, N_WIDE, N_NARROW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_q     <= 1'b0;
      run      <= 1'b0;
      tick     <= '0;
      wide_l   <= 1'b1;
      right_l  <= 1'b1;
      shift_l  <= 1'b0;
      line_pol <= 1'b0;
    end else begin
      ls_q <= line_start;
      if (ls_q) begin
        run      <= 1'b1;
        tick     <= '0;
        wide_l   <= wide_mode;
        right_l  <= dir_right;
        shift_l  <= ~line_pol;
        line_pol <= ~line_pol;
      end else if (run) begin
        if (tick == done_w) run <= 1'b0;
        else                tick <= tick + TW'(1);
      end
    end
  end

  AST_POL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ls_q |=> (line_pol != $past(line_pol))); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ls_q |=> ($stable(wide_l) && $stable(right_l) && $stable(shift_l))); // R9
  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tick <= done_w)); // R3

endmodule

// File: rtl/hdelta_hck_gen.sv
module hdelta_hck_gen #(
  parameter int unsigned N_WIDE   = 357,
  parameter int unsigned N_NARROW = 269,
  parameter int unsigned LEAD     = 2,
  parameter int unsigned OFS      = 6,
  parameter int unsigned TW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] tick,
  input  logic          wide_l,
  input  logic          shift_l,
  output logic          act_w,
  output logic [1:0]    ph_w,
  output logic          hst_q,
  output logic          hck1_q
);
  import hdelta_pkg::*;

  logic [TW-1:0] start_w;
  logic [TW-1:0] last_w;
  logic          hst_d;
  logic          hck1_d;

  assign start_w = TW'(first_tick(shift_l, LEAD, OFS));
  assign last_w  = start_w + TW'(span_ticks(wide_l, N_WIDE, N_NARROW));

  // burst covers ticks start+1 .. start+span
  assign act_w  = run && (tick > start_w) && (tick <= last_w);
  assign ph_w   = 2'(tick - start_w - TW'(1));
  assign hck1_d = act_w && !ph_w[1];
  assign hst_d  = run && (tick >= start_w) && (tick < start_w + TW'(DIV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst_q  <= 1'b0;
      hck1_q <= 1'b0;
    end else begin
      hst_q  <= hst_d;
      hck1_q <= hck1_d;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !hck1_q); // R1
  AST_HST_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hst_q) |-> !hck1_q); // R4

endmodule

// File: rtl/hdelta_sh_gen.sv
module hdelta_sh_gen (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        act,
  input  logic [1:0]                  ph,
  input  logic                        right,
  output logic [hdelta_pkg::NCH-1:0]  sh_q
);
  import hdelta_pkg::*;

  logic [NCH-1:0] sh_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sh_d[c] = act && (ph == sh_slot(c, right));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  AST_SH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sh_q)); // R8

endmodule

// File: rtl/hdelta_htiming.sv
module hdelta_htiming #(
  parameter int unsigned N_WIDE   = 357,
  parameter int unsigned N_NARROW = 269,
  parameter int unsigned LEAD     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       wide_mode,
  input  logic       dir_right,
  output logic       hst,
  output logic       hck1,
  output logic       hck2,
  output logic       dir_out,
  output logic       line_pol,
  output logic [2:0] sh_strobe
);
  import hdelta_pkg::*;

  localparam int unsigned HALF_OFS = (DIV * 3) / 2;
  localparam int unsigned TW = $clog2(LEAD + HALF_OFS + DIV * N_WIDE + 2) + 1;

  logic          run;
  logic [TW-1:0] tick;
  logic          wide_l;
  logic          right_l;
  logic          shift_l;
  logic          act_w;
  logic [1:0]    ph_w;
  logic          hck1_q;

  hdelta_line_ctrl #(
    .N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .LEAD(LEAD), .OFS(HALF_OFS), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .wide_mode(wide_mode),
    .dir_right(dir_right), .run(run), .tick(tick), .wide_l(wide_l),
    .right_l(right_l), .shift_l(shift_l), .line_pol(line_pol)
  );

  hdelta_hck_gen #(
    .N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .LEAD(LEAD), .OFS(HALF_OFS), .TW(TW)
  ) u_hck (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .wide_l(wide_l),
    .shift_l(shift_l), .act_w(act_w), .ph_w(ph_w), .hst_q(hst), .hck1_q(hck1_q)
  );

  hdelta_sh_gen u_sh (
    .clk(clk), .rst_n(rst_n), .act(act_w), .ph(ph_w), .right(right_l), .sh_q(sh_strobe)
  );

  assign hck1    = hck1_q;
  assign hck2    = ~hck1_q;
  assign dir_out = right_l;

endmodule

// File: tb/hdelta_htiming_bench.sv
module hdelta_htiming_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic       wide_mode = 1'b0;
  logic       dir_right = 1'b1;
  logic       hst, hck1, hck2, dir_out, line_pol;
  logic [2:0] sh_strobe;

  int vectors = 0;
  int errs = 0;
  bit exp_pol = 1'b0;
  localparam int FULL = 1445;

  hdelta_htiming u_hdelta_htiming (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .wide_mode(wide_mode),
    .dir_right(dir_right), .hst(hst), .hck1(hck1), .hck2(hck2), .dir_out(dir_out),
    .line_pol(line_pol), .sh_strobe(sh_strobe)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // model: k = index of reference cycles since the line began
  function automatic int m_lead(bit s);
    return 2 + (s ? 6 : 0);
  endfunction
  function automatic int m_count(bit w);
    return w ? 357 : 269;
  endfunction
  function automatic bit m_act(int k, bit w, bit s);
    int b = m_lead(s) + 1;
    return (k >= b) && (k < b + 4 * m_count(w));
  endfunction
  function automatic int m_hck1(int k, bit w, bit s);
    if (!m_act(k, w, s)) return 0;
    return (((k - m_lead(s) - 1) % 4) < 2) ? 1 : 0;
  endfunction
  function automatic int m_hst(int k, bit s);
    return ((k >= m_lead(s)) && (k < m_lead(s) + 4)) ? 1 : 0;
  endfunction
  function automatic int m_sh(int k, bit w, bit s, bit r);
    int q;
    if (!m_act(k, w, s)) return 0;
    q = (k - m_lead(s) - 1) % 4;
    if (q == 1) return 1;
    if (q == 2) return r ? 2 : 4;
    if (q == 3) return r ? 4 : 2;
    return 0;
  endfunction

  task automatic run_line(input bit w, input bit r, input int ncyc, input bit scr,
                          input bit after_cut);
    int rises = 0;
    bit prev = 1'b0;
    bit s;
    @(negedge clk);
    line_start = 1'b1; wide_mode = w; dir_right = r;
    @(negedge clk);
    line_start = 1'b0;
    exp_pol = !exp_pol;
    s = exp_pol;
    @(negedge clk);
    chk("R6 line_pol toggle", int'(line_pol), int'(exp_pol));
    chk("R7 dir_out latch", int'(dir_out), int'(r));
    for (int k = 0; k < ncyc; k++) begin
      if (scr) begin
        wide_mode = 1'($urandom % 2);
        dir_right = 1'($urandom % 2);
      end
      @(negedge clk);
      chk("R2 hck1 waveform", int'(hck1), m_hck1(k, w, s));
      chk("R1 hck2 complement", int'(hck2), 1 - m_hck1(k, w, s));
      chk(s ? "R5 hst shifted line" : "R4 hst timing", int'(hst), m_hst(k, s));
      chk("R8 strobes", int'(sh_strobe), m_sh(k, w, s, r));
      chk("R9 dir_out held", int'(dir_out), int'(r));
      if (hck1 && !prev) rises++;
      prev = hck1;
    end
    if (ncyc >= FULL)
      chk(after_cut ? "R10 edge count after restart" : "R3 edge count", rises, m_count(w));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    bit cut = 1'b0;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset hst", int'(hst), 0);
    chk("R11 reset hck1", int'(hck1), 0);
    chk("R11 reset hck2", int'(hck2), 1);
    chk("R11 reset strobes", int'(sh_strobe), 0);
    chk("R11 reset line_pol", int'(line_pol), 0);
    chk("R11 reset dir_out", int'(dir_out), 1);
    // idle input changes are ignored
    for (int i = 0; i < 6; i++) begin
      wide_mode = 1'(i % 2); dir_right = 1'(i % 3 == 0);
      @(negedge clk);
      chk("R9 idle dir_out", int'(dir_out), 1);
      chk("R9 idle hck1", int'(hck1), 0);
      chk("R9 idle line_pol", int'(line_pol), 0);
    end
    // directed: both aspects, both directions, both polarities
    run_line(1'b1, 1'b1, FULL, 1'b0, 1'b0);
    run_line(1'b0, 1'b0, FULL, 1'b0, 1'b0);
    run_line(1'b1, 1'b0, FULL, 1'b1, 1'b0);
    run_line(1'b0, 1'b1, FULL, 1'b1, 1'b0);
    // restarts mid-line (R10)
    run_line(1'b1, 1'b1, 40, 1'b0, 1'b0);
    run_line(1'b0, 1'b0, FULL, 1'b1, 1'b1);
    run_line(1'b0, 1'b1, 7, 1'b0, 1'b0);
    run_line(1'b1, 1'b0, FULL, 1'b0, 1'b1);
    // random lines
    for (int n = 0; n < 6; n++) begin
      bit w = 1'($urandom % 2);
      bit r = 1'($urandom % 2);
      bit c = ($urandom % 3) == 0;
      run_line(w, r, c ? 5 + int'($urandom % 1400) : FULL, 1'b1, cut);
      cut = c;
    end
    run_line(1'b1, 1'b1, FULL, 1'b1, cut);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule